// File: doc/BRIEF.md
# Zero-Operand Bypass Wrapper for a Double-Precision Adder

This block wraps a multi-stage double-precision adder datapath. It accepts two 64-bit operands with a valid/ready handshake and checks each one for a zero value. If either operand is zero, the result is already known. That operation skips the long datapath and is written into a short two-entry bypass buffer. Every other operation enters the main pipeline. In this project the main pipeline is a fixed-latency stub.

Each accepted operation also pushes one bit into an eight-entry path-record FIFO. The bit says which path the operation took. The output merge reads the oldest record and takes the next result from the path it names. Results therefore leave in the order they were accepted, even though zero-operand results finish sooner. The record FIFO is deep enough to cover the whole main-pipeline latency, so a steady stream of non-zero operations is accepted every cycle.

NaN and infinity handling are outside this block.

Top module: `zero_bypass_adder`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0. `in_ready` is 1.
- R2: An operand counts as zero when bits 62:0 are all zero. The sign bit 63 is ignored. An operation with at least one zero operand goes to the bypass buffer and never into the main pipeline.
- R3: If exactly one operand is zero, the result is the other operand, bit for bit.
- R4: If both operands are zero, the result is the AND of the two sign bits in bit 63, with bits 62:0 zero.
- R5: An operation with two non-zero operands goes through the main stub. Its result is `in_a + in_b` modulo 2^64, a placeholder for the real sum.
- R6: The result of a bypassed operation can be presented in the cycle after it is accepted. A main-pipeline result cannot appear before MAIN_LAT+1 cycles after acceptance. Each result appears as soon as it and all older results are available.
- R7: Results leave in exactly the order the operations were accepted, whichever path each took.
- R8: At most CTRL_DEPTH (8) operations are outstanding at once. When 8 are outstanding, `in_ready` is 0.
- R9: The bypass buffer holds at most BYP_DEPTH (2) results. When it is full, `in_ready` is 0 for an operation with a zero operand.
- R10: With `out_ready` held at 1, a continuous stream of non-zero operations is accepted on every cycle.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sum` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Operand pair is taken on this edge if valid |
| in_a | input | 64 | First double-precision operand |
| in_b | input | 64 | Second double-precision operand |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 64 | Result in issue order |

## Verification
The bench runs several kinds of traffic:
- Single isolated operations of each kind. These separate the bypass latency from the main latency and test the value rules for one zero and two zeros, including signed zeros.
- A main operation followed at once by a bypassed one. This shows whether the merge holds back the faster result.
- A dense non-zero stream with the consumer always ready. This shows whether the record FIFO depth costs throughput.
- Streams with the consumer stalled. These fill the bypass buffer and then the record FIFO, which tests the two acceptance limits separately.
- A long random mix of zero and non-zero operands with random backpressure. The model compares every output on every cycle against this traffic.

// File: rtl/zero_bypass_adder.sv
module zero_bypass_adder #(
  parameter int MAIN_LAT   = 6,
  parameter int CTRL_DEPTH = 8,
  parameter int BYP_DEPTH  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_sum
);
  localparam int CW  = $clog2(CTRL_DEPTH);
  localparam int CCW = $clog2(CTRL_DEPTH + 1);
  localparam int BW  = $clog2(BYP_DEPTH);
  localparam int BCW = $clog2(BYP_DEPTH + 1);

  logic            a_zero, b_zero, op_zero, in_fire, out_fire, head_byp;
  logic [63:0]     byp_res;

  logic            ctrl_mem [CTRL_DEPTH];
  logic [CW-1:0]   ctrl_wr, ctrl_rd;
  logic [CCW-1:0]  ctrl_cnt;

  logic [63:0]     byp_mem [BYP_DEPTH];
  logic [BW-1:0]   byp_wr, byp_rd;
  logic [BCW-1:0]  byp_cnt;

  logic [MAIN_LAT-1:0] pv;
  logic [63:0]     pd [MAIN_LAT];

  logic [63:0]     main_mem [CTRL_DEPTH];
  logic [CW-1:0]   main_wr, main_rd;
  logic [CCW-1:0]  main_cnt;

  logic            byp_push, byp_pop, main_push, main_pop;

  assign a_zero  = ~|in_a[62:0];
  assign b_zero  = ~|in_b[62:0];
  assign op_zero = a_zero | b_zero;
  assign byp_res = (a_zero && b_zero) ? {in_a[63] & in_b[63], 63'b0} :
                   a_zero ? in_b : in_a;

  assign in_ready  = (ctrl_cnt != CCW'(CTRL_DEPTH)) &&
                     (!op_zero || byp_cnt != BCW'(BYP_DEPTH));
  assign in_fire   = in_valid && in_ready;
  assign head_byp  = ctrl_mem[ctrl_rd];
  assign out_valid = (ctrl_cnt != '0) && (head_byp ? byp_cnt != '0 : main_cnt != '0);
  assign out_sum   = head_byp ? byp_mem[byp_rd] : main_mem[main_rd];
  assign out_fire  = out_valid && out_ready;

  assign byp_push  = in_fire && op_zero;
  assign byp_pop   = out_fire && head_byp;
  assign main_push = pv[MAIN_LAT-1];
  assign main_pop  = out_fire && !head_byp;

  // path record: 1 = bypass, 0 = main
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_wr  <= '0;
      ctrl_rd  <= '0;
      ctrl_cnt <= '0;
    end else begin
      if (in_fire) begin
        ctrl_mem[ctrl_wr] <= op_zero;
        ctrl_wr <= (ctrl_wr == CW'(CTRL_DEPTH - 1)) ? '0 : ctrl_wr + 1'b1;
      end
      if (out_fire)
        ctrl_rd <= (ctrl_rd == CW'(CTRL_DEPTH - 1)) ? '0 : ctrl_rd + 1'b1;
      ctrl_cnt <= ctrl_cnt + CCW'(in_fire) - CCW'(out_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_wr  <= '0;
      byp_rd  <= '0;
      byp_cnt <= '0;
    end else begin
      if (byp_push) begin
        byp_mem[byp_wr] <= byp_res;
        byp_wr <= (byp_wr == BW'(BYP_DEPTH - 1)) ? '0 : byp_wr + 1'b1;
      end
      if (byp_pop)
        byp_rd <= (byp_rd == BW'(BYP_DEPTH - 1)) ? '0 : byp_rd + 1'b1;
      byp_cnt <= byp_cnt + BCW'(byp_push) - BCW'(byp_pop);
    end
  end

  // fixed-latency stand-in for the full adder datapath
  always_ff @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[MAIN_LAT-2:0], in_fire && !op_zero};
  end

  always_ff @(posedge clk) begin
    pd[0] <= in_a + in_b;
    for (int i = 1; i < MAIN_LAT; i++) pd[i] <= pd[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_wr  <= '0;
      main_rd  <= '0;
      main_cnt <= '0;
    end else begin
      if (main_push) begin
        main_mem[main_wr] <= pd[MAIN_LAT-1];
        main_wr <= (main_wr == CW'(CTRL_DEPTH - 1)) ? '0 : main_wr + 1'b1;
      end
      if (main_pop)
        main_rd <= (main_rd == CW'(CTRL_DEPTH - 1)) ? '0 : main_rd + 1'b1;
      main_cnt <= main_cnt + CCW'(main_push) - CCW'(main_pop);
    end
  end

  AST_CTRL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_cnt <= CCW'(CTRL_DEPTH)); // R8
  AST_BYP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    byp_cnt <= BCW'(BYP_DEPTH)); // R9
  AST_MAIN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    main_push |-> (main_cnt < CCW'(CTRL_DEPTH) || main_pop)); // R8
  AST_RECORD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ctrl_cnt) == $countones(pv) + int'(main_cnt) + int'(byp_cnt)); // R7
  AST_ZERO_TO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && op_zero |=> byp_cnt != '0); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum)); // R11
endmodule

// File: tb/zero_bypass_adder_tb.sv
module zero_bypass_adder_tb;
  localparam int LAT = 6;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, out_ready = 0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        in_ready, out_valid;
  logic [63:0] out_sum;

  int checks = 0, fails = 0, cyc = 0, acc = 0;
  logic [63:0] q_res[$];
  int          q_rdy[$];
  int          q_kind[$];
  int          nbyp = 0;
  bit          prev_ov = 0, prev_or = 0;
  logic [63:0] prev_sum = '0;

  always #10 clk = ~clk;

  zero_bypass_adder #(.MAIN_LAT(LAT), .CTRL_DEPTH(8), .BYP_DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b, input bit ordy);
    bit za, zb, exp_ov, exp_ir;
    logic [63:0] r;
    int kind;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; out_ready = ordy;
    #1;
    za = (a[62:0] == 0);
    zb = (b[62:0] == 0);
    exp_ov = (q_res.size() > 0) && (q_rdy[0] <= cyc);
    exp_ir = (q_res.size() < 8) && (!(za || zb) || nbyp < 2);
    chk(out_valid == exp_ov, "R6,R7 out_valid", 64'(out_valid), 64'(exp_ov));
    if (exp_ov && out_valid)
      chk(out_sum == q_res[0],
          q_kind[0] == 0 ? "R5,R7 main result" : q_kind[0] == 1 ? "R2,R3 one-zero result" : "R4 two-zero result",
          out_sum, q_res[0]);
    if (prev_ov && !prev_or)
      chk(out_valid && out_sum == prev_sum, "R11 hold under stall", out_sum, prev_sum);
    chk(in_ready == exp_ir, "R8,R9,R10 in_ready", 64'(in_ready), 64'(exp_ir));
    prev_ov = out_valid; prev_or = ordy; prev_sum = out_sum;
    if (v && in_ready) acc++;
    if (exp_ov && ordy) begin
      if (q_kind[0] != 0) nbyp--;
      void'(q_res.pop_front()); void'(q_rdy.pop_front()); void'(q_kind.pop_front());
    end
    if (v && exp_ir) begin
      if (za && zb)  begin r = {a[63] & b[63], 63'b0}; kind = 2; end
      else if (za)   begin r = b; kind = 1; end
      else if (zb)   begin r = a; kind = 1; end
      else           begin r = a + b; kind = 0; end
      q_res.push_back(r);
      q_kind.push_back(kind);
      q_rdy.push_back(cyc + 1 + (kind == 0 ? LAT : 0));
      if (kind != 0) nbyp++;
    end
    cyc++;
  endtask

  function automatic logic [63:0] nz();
    logic [63:0] x = {$urandom, $urandom};
    if (x[62:0] == 0) x[5] = 1'b1;
    return x;
  endfunction

  function automatic logic [63:0] zr();
    return {1'($urandom), 63'b0};
  endfunction

  task automatic drain();
    for (int i = 0; i < 40; i++) step(0, '0, '0, 1);
    chk(q_res.size() == 0 && !out_valid, "R7 drained", 64'(q_res.size()), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid in reset", 64'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready in reset", 64'(in_ready), 1);
    @(negedge clk); rst_n = 1; #1;
    chk(out_valid == 0, "R1 out_valid after reset", 64'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready after reset", 64'(in_ready), 1);

    // R3, R6: single bypassed op
    step(1, 64'h0, 64'h4009_21FB_5444_2D18, 1);
    step(0, '0, '0, 1);
    chk(acc == 1 && q_res.size() == 0, "R6 bypass one-cycle latency", 64'(q_res.size()), 0);
    drain();
    // R4: signed zero combinations
    step(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1);
    step(1, 64'h8000_0000_0000_0000, 64'h0, 1);
    step(1, 64'h3FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1);
    drain();
    // R5, R6: single main op
    step(1, 64'h3FF0_0000_0000_0001, 64'h4000_0000_0000_0002, 1);
    drain();
    // R7: main op then a bypass op right behind it
    step(1, nz(), nz(), 1);
    step(1, zr(), nz(), 1);
    step(1, nz(), zr(), 1);
    step(1, nz(), nz(), 1);
    drain();

    // R10: full-rate non-zero stream
    acc = 0;
    for (int i = 0; i < 60; i++) step(1, nz(), nz(), 1);
    chk(acc == 60, "R10 accepted every cycle", 64'(acc), 64'd60);
    drain();

    // R9: stalled consumer, zero operands fill bypass buffer
    acc = 0;
    for (int i = 0; i < 6; i++) step(1, zr(), nz(), 0);
    chk(acc == 2, "R9 bypass buffer limit", 64'(acc), 64'd2);
    // R8: non-zero ops fill the remaining record entries
    acc = 0;
    for (int i = 0; i < 14; i++) step(1, nz(), nz(), 0);
    chk(acc == 6, "R8 outstanding limit", 64'(acc), 64'd6);
    drain();

    // random mix with random backpressure
    for (int i = 0; i < 4000; i++) begin
      int s = $urandom_range(0, 9);
      step($urandom_range(0, 3) != 0,
           s < 3 ? zr() : nz(),
           (s == 1 || s == 4) ? zr() : nz(),
           $urandom_range(0, 3) != 0);
    end
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule